// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Interrupt Bridge

This block places a shared register window of 256 bytes between two buses. On one side is a 32-bit host I/O port with byte-lane enables. On the other is an 8-bit microcontroller port. Both sides read and write the same bytes. Two bytes of the window act as mailboxes. The host-to-coprocessor mailbox is at byte 2Fh, and a host write to it raises a request line to the coprocessor. The coprocessor-to-host mailbox is at byte 0Fh. A coprocessor write there raises a host-visible code flag and, when enabled, pulls an open-drain, active-low host interrupt line low.

The top dword (FCh..FFh) is not shared storage. Byte FCh holds the host interrupt enable in bit 4, and byte FEh is a read-only status byte. Two state machines hold all flags, and both are synchronous to one clock.

The host interrupt machine has three states:
- `HI_IDLE`: no code waiting.
- `HI_PEND`: a code is waiting, but the line is not driven.
- `HI_DRIVE`: a code is waiting and the line is pulled low.

Its transitions:
- A coprocessor code write moves to `HI_DRIVE` when the enable is set, and otherwise to `HI_PEND`.
- A host mailbox read moves to `HI_IDLE`.
- When a code write and a mailbox read arrive in the same cycle, the code write wins.

The command machine has two states, `CB_READY` and `CB_BUSY`:
- A host mailbox hit moves it to `CB_BUSY`.
- A coprocessor read of byte 2Fh returns it to `CB_READY`, unless a new hit arrives in the same cycle.

Top module: `mbx_bridge`

## Requirements
- R1: A host write updates only the bytes of the addressed dword whose lane enable is set (lane k is byte offset k, data bits 8k+7:8k). A host read returns all four bytes of the dword, combinationally, in the same little-endian lane order.
- R2: The coprocessor reads and writes single bytes of the same storage. A byte written by one side reads back the same on the other side.
- R3: Any host write whose dword is 0Bh and whose lane 3 enable is set counts as a host mailbox hit (byte, word or dword width). A write to dword 0Bh with lane 3 disabled is not a hit.
- R4: A host mailbox hit sets `cop_irq` and status bit 2 (busy) from the next cycle. A coprocessor read of byte 2Fh clears both from the next cycle.
- R5: A coprocessor write to byte 0Fh sets status bit 0 (code flag) from the next cycle.
- R6: A host read of dword 03h with lane 3 enabled clears the code flag and status bit 1 and releases the line (`hirq_oe` low) from the next cycle. A host read of dword 03h with lane 3 disabled changes none of them.
- R7: The enable takes host data bit 4 only on a write to dword 3Fh with all four lanes enabled. A write there with any other lane pattern leaves it unchanged. The enable reads back at status bit 4 and at bit 4 of byte FCh. All other bits of the top dword read 0, and the status byte is not writable.
- R8: Changing the enable never changes `hirq_oe` in that cycle or the next.
- R9: A coprocessor write to byte 0Fh while the enable is set drives the line from the next cycle: `hirq_oe` high, `hirq_o` low, and status bit 1 high.
- R10: After reset the shared bytes are 0, the enable is 0, all status bits are 0, `hirq_oe` is low and `cop_irq` is low.
- R11: Coprocessor reads of FCh..FFh return 0. Coprocessor writes there change nothing the host can see.
- R12: When both sides write the same shared byte in the same cycle, the coprocessor's byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_dw | input | 6 | Host dword address (byte address bits 7:2) |
| h_be | input | 4 | Host byte-lane enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational |
| c_wr | input | 1 | Coprocessor write strobe |
| c_rd | input | 1 | Coprocessor read strobe |
| c_addr | input | 8 | Coprocessor byte address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data, combinational |
| cop_irq | output | 1 | Interrupt request to the coprocessor, active high |
| hirq_o | output | 1 | Host interrupt data, always 0 |
| hirq_oe | output | 1 | Host interrupt driver enable; high pulls the line low |

## Verification
The assertions assume that every host or coprocessor strobe lasts exactly one cycle and that `h_wr` and `h_rd` are never high together. They also assume the enable is the only internal state they observe. The hold property for the line therefore relies on the line changing only through mailbox traffic. The stimulus drives one access per task and returns all strobes low before the next access. The only overlap is the deliberate same-cycle write by both sides in the collision test, which touches the two different write strobes and leaves the read strobes low.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        HI_IDLE  = 2'd0,
        HI_PEND  = 2'd1,
        HI_DRIVE = 2'd2
    } hirq_state_e;

    typedef enum logic {
        CB_READY = 1'b0,
        CB_BUSY  = 1'b1
    } cmd_state_e;

    localparam int unsigned LANES     = 4;
    localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/mbx_lane_dec.sv
module mbx_lane_dec #(
    parameter int unsigned    AW       = 8,
    parameter logic [AW-1:0]  H2C_ADDR = 'h2F,
    parameter logic [AW-1:0]  C2H_ADDR = 'h0F
) (
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [AW-3:0] h_dw,
    input  logic [3:0]    h_be,
    output logic          ram_wr,
    output logic          h2c_hit,
    output logic          c2h_rd_hit,
    output logic          ctrl_wr
);
    localparam logic [AW-3:0] CTRL_DW = '1;
    localparam logic [AW-3:0] H2C_DW  = H2C_ADDR[AW-1:2];
    localparam logic [AW-3:0] C2H_DW  = C2H_ADDR[AW-1:2];
    localparam int unsigned   H2C_LN  = int'(H2C_ADDR[1:0]);
    localparam int unsigned   C2H_LN  = int'(C2H_ADDR[1:0]);

    always_comb begin
        ram_wr     = h_wr && (h_dw != CTRL_DW);
        h2c_hit    = h_wr && (h_dw == H2C_DW) && h_be[H2C_LN];
        c2h_rd_hit = h_rd && (h_dw == C2H_DW) && h_be[C2H_LN];
        ctrl_wr    = h_wr && (h_dw == CTRL_DW) && (h_be == 4'hF);
    end
endmodule

// File: rtl/mbx_hirq_fsm.sv
module mbx_hirq_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic code_wr,
    input  logic code_rd,
    input  logic irq_en,
    output logic code_flag,
    output logic drive
);
    hirq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HI_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HI_IDLE: begin
                if (code_wr) state_d = irq_en ? HI_DRIVE : HI_PEND;
            end
            HI_PEND: begin
                if (code_wr)      state_d = irq_en ? HI_DRIVE : HI_PEND;
                else if (code_rd) state_d = HI_IDLE;
            end
            HI_DRIVE: begin
                if (code_wr)      state_d = HI_DRIVE;
                else if (code_rd) state_d = HI_IDLE;
            end
            default: state_d = HI_IDLE;
        endcase
    end

    always_comb begin
        code_flag = (state_q != HI_IDLE);
        drive     = (state_q == HI_DRIVE);
    end
endmodule

// File: rtl/mbx_cmd_fsm.sv
module mbx_cmd_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_rd,
    output logic busy
);
    cmd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CB_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CB_READY: if (cmd_wr)            state_d = CB_BUSY;
            CB_BUSY:  if (cmd_rd && !cmd_wr) state_d = CB_READY;
            default:                         state_d = CB_READY;
        endcase
    end

    always_comb busy = (state_q == CB_BUSY);
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
    import mbx_pkg::*;
#(
    parameter int unsigned    AW       = 8,
    parameter logic [AW-1:0]  H2C_ADDR = 'h2F,
    parameter logic [AW-1:0]  C2H_ADDR = 'h0F,
    parameter int unsigned    EN_BIT   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [AW-3:0] h_dw,
    input  logic [3:0]    h_be,
    input  logic [31:0]   h_wdata,
    output logic [31:0]   h_rdata,
    input  logic          c_wr,
    input  logic          c_rd,
    input  logic [AW-1:0] c_addr,
    input  logic [7:0]    c_wdata,
    output logic [7:0]    c_rdata,
    output logic          cop_irq,
    output logic          hirq_o,
    output logic          hirq_oe
);
    localparam int unsigned   WIN_BYTES = 1 << AW;
    localparam logic [AW-3:0] CTRL_DW   = '1;

    logic [LANE_BITS-1:0] mem [WIN_BYTES];
    logic                 ram_wr, h2c_hit, c2h_rd_hit, ctrl_wr;
    logic                 en_q, code_flag, drive, busy;
    logic                 c_in_ctrl, code_wr, cmd_rd;
    logic [7:0]           status, ctrl_b0;

    mbx_lane_dec #(.AW(AW), .H2C_ADDR(H2C_ADDR), .C2H_ADDR(C2H_ADDR)) u_dec (
        .h_wr(h_wr), .h_rd(h_rd), .h_dw(h_dw), .h_be(h_be),
        .ram_wr(ram_wr), .h2c_hit(h2c_hit), .c2h_rd_hit(c2h_rd_hit),
        .ctrl_wr(ctrl_wr)
    );

    always_comb begin
        c_in_ctrl = (c_addr[AW-1:2] == CTRL_DW);
        code_wr   = c_wr && (c_addr == C2H_ADDR);
        cmd_rd    = c_rd && (c_addr == H2C_ADDR);
    end

    generate
        for (genvar i = 0; i < int'(WIN_BYTES); i++) begin : g_byte
            localparam logic [AW-1:0] BA = AW'(i);
            logic h_hit, c_hit;
            always_comb begin
                h_hit = ram_wr && (h_dw == BA[AW-1:2]) && h_be[BA[1:0]];
                c_hit = c_wr && !c_in_ctrl && (c_addr == BA);
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     mem[i] <= '0;
                else if (c_hit) mem[i] <= c_wdata;
                else if (h_hit) mem[i] <= h_wdata[8*(i%4) +: 8];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (ctrl_wr) en_q <= h_wdata[EN_BIT];
    end

    mbx_hirq_fsm u_hirq (
        .clk(clk), .rst_n(rst_n), .code_wr(code_wr), .code_rd(c2h_rd_hit),
        .irq_en(en_q), .code_flag(code_flag), .drive(drive)
    );

    mbx_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(h2c_hit), .cmd_rd(cmd_rd),
        .busy(busy)
    );

    always_comb begin
        status  = {3'b000, en_q, 1'b0, busy, drive, code_flag};
        ctrl_b0 = '0;
        ctrl_b0[EN_BIT] = en_q;
        if (h_dw == CTRL_DW)
            h_rdata = {8'h00, status, 8'h00, ctrl_b0};
        else
            h_rdata = {mem[{h_dw, 2'd3}], mem[{h_dw, 2'd2}],
                       mem[{h_dw, 2'd1}], mem[{h_dw, 2'd0}]};
        c_rdata = c_in_ctrl ? 8'h00 : mem[c_addr];
        cop_irq = busy;
        hirq_o  = 1'b0;
        hirq_oe = drive;
    end
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
    parameter int unsigned    AW       = 8,
    parameter logic [AW-1:0]  H2C_ADDR = 'h2F,
    parameter logic [AW-1:0]  C2H_ADDR = 'h0F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_wr,
    input logic          h_rd,
    input logic [AW-3:0] h_dw,
    input logic [3:0]    h_be,
    input logic          c_wr,
    input logic          c_rd,
    input logic [AW-1:0] c_addr,
    input logic          cop_irq,
    input logic          hirq_oe,
    input logic          en_q
);
    localparam logic [AW-3:0] CTRL_DW = '1;

    logic code_w, code_r, cmd_w, cmd_r;
    always_comb begin
        code_w = c_wr && (c_addr == C2H_ADDR);
        code_r = h_rd && (h_dw == C2H_ADDR[AW-1:2]) && h_be[C2H_ADDR[1:0]];
        cmd_w  = h_wr && (h_dw == H2C_ADDR[AW-1:2]) && h_be[H2C_ADDR[1:0]];
        cmd_r  = c_rd && (c_addr == H2C_ADDR);
    end

    // R9
    drive_on_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_w && en_q |=> hirq_oe);

    // R6
    release_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_r && !code_w |=> !hirq_oe);

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_w && !code_r |=> (hirq_oe == $past(hirq_oe)));

    // R3
    cmd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w |=> cop_irq);

    // R4
    cmd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_r && !cmd_w |=> !cop_irq);

    // R7
    en_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr && (h_dw == CTRL_DW) && (h_be != 4'hF) |=> $stable(en_q));
endmodule

bind mbx_bridge mbx_bridge_chk #(
    .AW(AW), .H2C_ADDR(H2C_ADDR), .C2H_ADDR(C2H_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_dw(h_dw),
    .h_be(h_be), .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr),
    .cop_irq(cop_irq), .hirq_oe(hirq_oe), .en_q(en_q)
);

// File: tb/test_mbx_bridge.sv
module test_mbx_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 0, h_rd = 0, c_wr = 0, c_rd = 0;
    logic [5:0]  h_dw = '0;
    logic [3:0]  h_be = '0;
    logic [31:0] h_wdata = '0, h_rdata;
    logic [7:0]  c_addr = '0, c_wdata = '0, c_rdata;
    logic        cop_irq, hirq_o, hirq_oe;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    mbx_bridge i_mbx_bridge (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_dw(h_dw),
        .h_be(h_be), .h_wdata(h_wdata), .h_rdata(h_rdata), .c_wr(c_wr),
        .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .cop_irq(cop_irq), .hirq_o(hirq_o), .hirq_oe(hirq_oe)
    );

    // {dword, lanes, write data, expected read-back} for R1
    localparam logic [73:0] VEC [6] = '{
        {6'h01, 4'hF, 32'h11223344, 32'h11223344},
        {6'h01, 4'h3, 32'hAABBCCDD, 32'h1122CCDD},
        {6'h02, 4'hA, 32'h55667788, 32'h55007700},
        {6'h02, 4'h5, 32'h99AABBCC, 32'h55AA77CC},
        {6'h10, 4'h8, 32'hDEADBEEF, 32'hDE000000},
        {6'h10, 4'h0, 32'hFFFFFFFF, 32'hDE000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk); h_wr = 1; h_dw = dw; h_be = be; h_wdata = d;
        @(negedge clk); h_wr = 0; h_be = '0;
    endtask

    task automatic hr(input logic [5:0] dw, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk); h_rd = 1; h_dw = dw; h_be = be;
        #1 d = h_rdata;
        @(negedge clk); h_rd = 0; h_be = '0;
    endtask

    task automatic cw(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); c_wr = 1; c_addr = a; c_wdata = d;
        @(negedge clk); c_wr = 0;
    endtask

    task automatic cr(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); c_rd = 1; c_addr = a;
        #1 d = c_rdata;
        @(negedge clk); c_rd = 0;
    endtask

    task automatic st(output logic [7:0] s);
        logic [31:0] w;
        hr(6'h3F, 4'h4, w);
        s = w[23:16];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [7:0]  b, s;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        chk("R10 hirq_oe", 32'(hirq_oe), 0);
        chk("R10 cop_irq", 32'(cop_irq), 0);
        hr(6'h3F, 4'hF, w); chk("R10 top dword", w, 0);
        hr(6'h0B, 4'hF, w); chk("R10 shared bytes", w, 0);

        // R1 table walk
        for (int k = 0; k < 6; k++) begin
            hw(VEC[k][73:68], VEC[k][67:64], VEC[k][63:32]);
            hr(VEC[k][73:68], 4'hF, w);
            chk($sformatf("R1 vector %0d", k), w, VEC[k][31:0]);
        end

        // R2 shared view
        cr(8'h43, b); chk("R2 cop reads host byte", 32'(b), 32'hDE);
        cw(8'h44, 8'h5A);
        hr(6'h11, 4'hF, w); chk("R2 host reads cop byte", w, 32'h0000005A);

        // R3 / R4 mailbox hits from every width
        hw(6'h0B, 4'h8, 32'h21000000);
        chk("R3 byte hit irq", 32'(cop_irq), 1);
        st(s); chk("R4 busy bit", 32'(s), 32'h04);
        cr(8'h2F, b); chk("R4 command byte", 32'(b), 32'h21);
        chk("R4 irq dropped", 32'(cop_irq), 0);
        st(s); chk("R4 busy cleared", 32'(s), 0);
        hw(6'h0B, 4'hC, 32'h22000000);
        chk("R3 word hit irq", 32'(cop_irq), 1);
        cr(8'h2F, b); chk("R3 word byte", 32'(b), 32'h22);
        hw(6'h0B, 4'hF, 32'h23000000);
        chk("R3 dword hit irq", 32'(cop_irq), 1);
        cr(8'h2F, b);
        hw(6'h0B, 4'h7, 32'hFFFFFFFF);
        chk("R3 lane3 off no irq", 32'(cop_irq), 0);

        // R5 / R6 polled code
        cw(8'h0F, 8'h13);
        st(s); chk("R5 code flag", 32'(s), 32'h01);
        chk("R5 line idle when disabled", 32'(hirq_oe), 0);
        hr(6'h03, 4'h7, w);
        st(s); chk("R6 read without lane3 keeps flag", 32'(s), 32'h01);
        hr(6'h03, 4'h8, w); chk("R6 code value", 32'(w[31:24]), 32'h13);
        st(s); chk("R6 flag cleared", 32'(s), 0);

        // R7 enable register
        hw(6'h3F, 4'h3, 32'h00000010);
        st(s); chk("R7 partial write ignored", 32'(s), 0);
        hw(6'h3F, 4'hF, 32'h00FF0010);
        hr(6'h3F, 4'hF, w); chk("R7 enable readback", w, 32'h00100010);
        hw(6'h3F, 4'hF, 32'h00000000);
        st(s); chk("R7 disabled", 32'(s), 0);

        // R8 / R9 interrupt line
        cw(8'h0F, 8'h50);
        hw(6'h3F, 4'hF, 32'h00000010);
        chk("R8 enable keeps line", 32'(hirq_oe), 0);
        st(s); chk("R8 status pend+en", 32'(s), 32'h11);
        cw(8'h0F, 8'h51);
        chk("R9 line driven", 32'(hirq_oe), 1);
        chk("R9 line low", 32'(hirq_o), 0);
        st(s); chk("R9 status drive", 32'(s), 32'h13);
        hw(6'h3F, 4'hF, 32'h00000000);
        chk("R8 disable keeps line", 32'(hirq_oe), 1);
        hr(6'h03, 4'h8, w); chk("R6 latest code", 32'(w[31:24]), 32'h51);
        chk("R6 line released", 32'(hirq_oe), 0);
        st(s); chk("R6 status clear", 32'(s), 0);

        // R11 coprocessor has no view of the top dword
        cw(8'h0F, 8'h60);
        cr(8'hFE, b); chk("R11 cop read status", 32'(b), 0);
        cw(8'hFC, 8'hFF);
        hr(6'h3F, 4'hF, w); chk("R11 cop write ignored", w, 32'h00010000);
        hr(6'h03, 4'h8, w);

        // R12 same-cycle write collision
        @(negedge clk);
        h_wr = 1; h_dw = 6'h05; h_be = 4'hF; h_wdata = 32'hAABBCCDD;
        c_wr = 1; c_addr = 8'h14; c_wdata = 8'h77;
        @(negedge clk);
        h_wr = 0; h_be = '0; c_wr = 0;
        hr(6'h05, 4'hF, w); chk("R12 cop wins", w, 32'hAABBCC77);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule